// File: doc/BRIEF.md
# Output-Disable Request Detector

This block watches a small set of active-low request inputs. Each one asks for the chip's output pins to be placed in high impedance. For every input it keeps a sticky request flag, and it drives a single interrupt when any flag is set and the interrupt is enabled. Each input has its own two-bit mode. The mode picks either falling-edge detection or low-level detection. In low-level detection the input must read low on sixteen consecutive samples, taken at one of three divided rates of the block clock.

Software sees two registers through a simple read/write port. The control register holds the mode fields and the interrupt enable. The flag register holds the request flags. Clearing a flag takes a handshake: software must first read the flag as 1 and then write 0 to it. In the level modes, the input must also have been sampled high since the flag was set.

Top module: `odreq_detect`

## Requirements
- R1: After reset, every flag, mode field and the interrupt enable are 0, `irq_o` is low and both registers read 0.
- R2: In mode 00 a falling edge on `req_n_i[i]` sets `flag_o[i]` by the third rising clock edge after the change. A level held low after the flag is cleared does not set the flag again.
- R3: Modes 01, 10 and 11 sample the input every 8, 16 and 128 clocks. The flag sets only after sixteen consecutive low samples and stays clear while fewer have been taken.
- R4: A high sample during a low run resets the run count, so the run must start again from zero.
- R5: Writing 0 to a flag bit clears it only if that flag was read as 1 since it was set. Without that read the write is ignored.
- R6: In modes 01, 10 and 11 a clearing write is ignored until the input has been sampled high since the flag was set.
- R7: Writing 1 to a flag bit leaves that flag unchanged.
- R8: A flag that sets in the same cycle as a valid clearing write stays set.
- R9: `irq_o` is high exactly when the interrupt enable is 1 and at least one flag is 1.
- R10: Address 0 is the control register. Bits [2i+1:2i] hold the mode of input i and bit 8 is the interrupt enable. Address 1 is the flag register, with flag i in bit i. All other bits read 0 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Read strobe (arms flags read as 1) |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 1 | 0 = control, 1 = flags |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| req_n_i | input | 4 | Active-low output-disable requests |
| flag_o | output | 4 | Sticky request flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
The edge mode is tried with a single falling step and with a low level that is held after the flag is cleared. Together they show that a transition sets the flag and a steady level does not. Each level mode is tried with a low run that stops short of sixteen samples and with one that reaches it, which pins down the rate and the run length. A run broken by a short high pulse shows that the count restarts. The clearing handshake is tried without a read, with a write of 1, with the input still low in a level mode, and with a clearing write placed in the same cycle as a new edge.

// File: rtl/odreq_pkg.sv
package odreq_pkg;
  localparam int DATA_W    = 16;
  localparam int MODE_W    = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  typedef enum logic [MODE_W-1:0] {
    MODE_EDGE  = 2'b00,
    MODE_LVL_A = 2'b01,
    MODE_LVL_B = 2'b10,
    MODE_LVL_C = 2'b11
  } det_mode_e;
endpackage

// File: rtl/odreq_prescaler.sv
module odreq_prescaler #(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] stb_o
);
  localparam int CNT_W = $clog2(DIV_C);
  localparam logic [CNT_W-1:0] MASK_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] MASK_B = CNT_W'(DIV_B - 1);
  localparam logic [CNT_W-1:0] MASK_C = CNT_W'(DIV_C - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stb_o[0] = ((cnt_q & MASK_A) == MASK_A);
  assign stb_o[1] = ((cnt_q & MASK_B) == MASK_B);
  assign stb_o[2] = ((cnt_q & MASK_C) == MASK_C);
endmodule

// File: rtl/odreq_chan.sv
module odreq_chan
  import odreq_pkg::*;
#(
  parameter int RUN_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_n_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [2:0]        stb_i,
  input  logic              rd_arm_i,
  input  logic              wr_zero_i,
  output logic              flag_o,
  output logic              pin_s_o
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic s1_q, s2_q, prev_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic flag_q, flag_d, armed_q, armed_d, high_q, high_d;
  logic level_mode, sel_stb, edge_hit, level_hit, set_hit, clr_ok;

  always_comb begin
    level_mode = (det_mode_e'(mode_i) != MODE_EDGE);
    unique case (det_mode_e'(mode_i))
      MODE_LVL_A: sel_stb = stb_i[0];
      MODE_LVL_B: sel_stb = stb_i[1];
      MODE_LVL_C: sel_stb = stb_i[2];
      default:    sel_stb = 1'b0;
    endcase
  end

  always_comb begin
    run_d = run_q;
    if (!level_mode)            run_d = '0;
    else if (sel_stb) begin
      if (s2_q)                 run_d = '0;
      else if (run_q != RUN_LAST) run_d = run_q + RUN_W'(1);
    end
  end

  always_comb begin
    edge_hit  = !level_mode && prev_q && !s2_q;
    level_hit = level_mode && sel_stb && !s2_q && (run_q == RUN_LAST);
    set_hit   = edge_hit || level_hit;
    clr_ok    = wr_zero_i && armed_q && (!level_mode || high_q);

    flag_d = flag_q;
    if (set_hit)     flag_d = 1'b1;
    else if (clr_ok) flag_d = 1'b0;

    armed_d = armed_q;
    if (!flag_d || (set_hit && !flag_q)) armed_d = 1'b0;
    else if (rd_arm_i && flag_q)         armed_d = 1'b1;

    high_d = high_q;
    if (!flag_d || (set_hit && !flag_q))   high_d = 1'b0;
    else if (level_mode && sel_stb && s2_q) high_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      run_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      high_q  <= 1'b0;
    end else begin
      s1_q    <= pin_n_i;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      run_q   <= run_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
      high_q  <= high_d;
    end
  end

  assign flag_o  = flag_q;
  assign pin_s_o = s2_q;
endmodule

// File: rtl/odreq_regfile.sv
module odreq_regfile
  import odreq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_rd,
  input  logic                       reg_wr,
  input  logic                       reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic [NUM_PINS-1:0]        flags_i,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic [NUM_PINS*MODE_W-1:0] modes_o,
  output logic                       irq_en_o,
  output logic [NUM_PINS-1:0]        rd_arm_o,
  output logic [NUM_PINS-1:0]        wr_zero_o
);
  localparam int MODE_BITS = NUM_PINS * MODE_W;
  localparam int EN_BIT    = MODE_BITS;

  logic [MODE_BITS-1:0] modes_q, modes_d;
  logic                 en_q, en_d;
  logic                 ctrl_we, flag_we;
  logic                 unused_wdata_bits;

  assign ctrl_we = reg_wr && (reg_addr == ADDR_CTRL);
  assign flag_we = reg_wr && (reg_addr == ADDR_FLAG);
  assign unused_wdata_bits = ^reg_wdata[DATA_W-1:EN_BIT+1];

  always_comb begin
    modes_d = modes_q;
    en_d    = en_q;
    if (ctrl_we) begin
      modes_d = reg_wdata[MODE_BITS-1:0];
      en_d    = reg_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modes_q <= '0;
      en_q    <= 1'b0;
    end else begin
      modes_q <= modes_d;
      en_q    <= en_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_strobe
      assign rd_arm_o[g]  = reg_rd && (reg_addr == ADDR_FLAG);
      assign wr_zero_o[g] = flag_we && !reg_wdata[g];
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_FLAG) begin
      reg_rdata[NUM_PINS-1:0] = flags_i;
    end else begin
      reg_rdata[MODE_BITS-1:0] = modes_q;
      reg_rdata[EN_BIT]        = en_q;
    end
  end

  assign modes_o  = modes_q;
  assign irq_en_o = en_q;
endmodule

// File: rtl/odreq_detect.sv
module odreq_detect
  import odreq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int RUN_LEN  = 16,
  parameter int DIV_A    = 8,
  parameter int DIV_B    = 16,
  parameter int DIV_C    = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic                reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] req_n_i,
  output logic [NUM_PINS-1:0] flag_o,
  output logic                irq_o
);
  logic [1:0]                 rst_q;
  logic                       rst_n_s;
  logic [2:0]                 stb;
  logic [NUM_PINS*MODE_W-1:0] modes;
  logic                       irq_en;
  logic [NUM_PINS-1:0]        rd_arm, wr_zero, flags, pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  odreq_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) presc_i (
    .clk(clk), .rst_n(rst_n_s), .stb_o(stb)
  );

  odreq_regfile #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk(clk), .rst_n(rst_n_s), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flags_i(flags),
    .reg_rdata(reg_rdata), .modes_o(modes), .irq_en_o(irq_en),
    .rd_arm_o(rd_arm), .wr_zero_o(wr_zero)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_chan
      odreq_chan #(.RUN_LEN(RUN_LEN)) chan_i (
        .clk(clk), .rst_n(rst_n_s), .pin_n_i(req_n_i[g]),
        .mode_i(modes[g*MODE_W +: MODE_W]), .stb_i(stb),
        .rd_arm_i(rd_arm[g]), .wr_zero_i(wr_zero[g]),
        .flag_o(flags[g]), .pin_s_o(pin_s[g])
      );
    end
  endgenerate

  assign flag_o = flags;
  assign irq_o  = irq_en && (|flags);
endmodule

// File: rtl/odreq_detect_chk.sv
module odreq_detect_chk
  import odreq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic                reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_PINS-1:0] flag_o,
  input logic [NUM_PINS-1:0] pin_s,
  input logic                irq_o
);
  localparam int TOP_USED = NUM_PINS * MODE_W;

  a_r9_no_irq_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o == '0) |-> !irq_o);

  a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flag_o) & ~flag_o)) |-> $past(reg_wr && (reg_addr == ADDR_FLAG)));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:TOP_USED+1] == '0);

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_bit
      a_r7_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && (reg_addr == ADDR_FLAG) && reg_wdata[g] && flag_o[g]) |-> flag_o[g]);
      a_r3_set_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o[g]) |-> !$past(pin_s[g]));
    end
  endgenerate
endmodule

bind odreq_detect odreq_detect_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_o(flag_o),
  .pin_s(pin_s), .irq_o(irq_o)
);

// File: tb/odreq_detect_tb_top.sv
module odreq_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  req_n = 4'hF;
  logic [3:0]  flag_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  odreq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_n_i(req_n), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(1'b0, d); chk("R1 ctrl", d, 0);
    rd(1'b1, d); chk("R1 flags reg", d, 0);
    chk("R1 flag_o", flag_o, 0);
    chk("R1 irq_o", irq_o, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(1'b0, 16'hFFFF);
    rd(1'b0, d); chk("R10 ctrl readback", d, 16'h01FF);
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, d); chk("R10 flag reg reserved", d, 0);
  endtask

  task automatic t_edge();
    req_n[0] = 1'b0;
    cyc(3);
    chk("R2 edge sets flag", flag_o, 4'b0001);
    chk("R9 irq gated off", irq_o, 0);
    wr(1'b0, 16'h0100);
    chk("R9 irq on", irq_o, 1);
  endtask

  task automatic t_clear_edge();
    logic [15:0] d;
    wr(1'b1, 16'hFFFE);
    chk("R5 write0 without read", flag_o, 4'b0001);
    rd(1'b1, d); chk("R10 flag read", d, 16'h0001);
    wr(1'b1, 16'hFFFF);
    chk("R7 write1 no effect", flag_o, 4'b0001);
    wr(1'b1, 16'hFFFE);
    chk("R5 read then write0 clears", flag_o, 0);
    chk("R9 irq off after clear", irq_o, 0);
    cyc(20);
    chk("R2 held low no retrigger", flag_o, 0);
    req_n[0] = 1'b1;
    cyc(6);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    req_n[0] = 1'b0; cyc(4);
    req_n[0] = 1'b1; cyc(6);
    rd(1'b1, d);
    chk("R8 setup flag", d, 16'h0001);
    wr(1'b1, 16'hFFFE);
    chk("R8 cleared", flag_o, 0);
    req_n[0] = 1'b0; cyc(4);
    req_n[0] = 1'b1; cyc(6);
    rd(1'b1, d);
    req_n[0] = 1'b0;
    cyc(2);
    wr(1'b1, 16'hFFFE);
    chk("R8 set wins over clear", flag_o, 4'b0001);
    rd(1'b1, d);
    wr(1'b1, 16'hFFFE);
    chk("R8 cleanup", flag_o, 0);
    req_n[0] = 1'b1; cyc(6);
  endtask

  task automatic t_level(input int pin, input int div);
    req_n[pin] = 1'b0;
    cyc(14 * div);
    chk($sformatf("R3 short run pin%0d", pin), flag_o[pin], 0);
    cyc(3 * div + 10);
    chk($sformatf("R3 full run pin%0d", pin), flag_o[pin], 1);
  endtask

  task automatic t_level_clear(input int pin, input int div);
    logic [15:0] d;
    logic [15:0] m;
    m = ~(16'h1 << pin);
    rd(1'b1, d);
    wr(1'b1, m);
    chk($sformatf("R6 low blocks clear pin%0d", pin), flag_o[pin], 1);
    req_n[pin] = 1'b1;
    cyc(2 * div + 10);
    wr(1'b1, m);
    chk($sformatf("R6 clear after high pin%0d", pin), flag_o[pin], 0);
  endtask

  task automatic t_restart();
    req_n[1] = 1'b0; cyc(100);
    req_n[1] = 1'b1; cyc(20);
    req_n[1] = 1'b0; cyc(100);
    chk("R4 broken run no flag", flag_o[1], 0);
    cyc(60);
    chk("R4 restarted run sets", flag_o[1], 1);
    t_level_clear(1, 8);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_regs();
    t_edge();
    t_clear_edge();
    t_set_wins();
    wr(1'b0, 16'h01E4);
    t_level(1, 8);
    t_level(2, 16);
    t_level(3, 128);
    t_level_clear(3, 128);
    t_level_clear(1, 8);
    t_level_clear(2, 16);
    t_restart();
    chk("R9 irq low with no flags", irq_o, 0);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=done", n);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule